// File: doc/BRIEF.md
# Field-Blocked Segment Deinterleaver

This block takes a stream of 32-bit words grouped into fixed segments and turns it back into per-sample records. Each segment is one row of 3 × LANES words. The first LANES words are analog values. The next LANES words are the lower halves of the sample timestamps. The last LANES words are the upper halves. The record for lane i joins the analog word of lane i with the two timestamp halves of lane i into one 64-bit stamp.

A plain three-way rotation cannot split this layout, because consecutive words belong to the same field and not to the same sample. The block therefore keeps a whole segment's analog and lower-half words in storage. It releases a record as soon as that lane's upper half has arrived, always in lane order. Records leave through a valid/ready handshake. The input also uses a valid/ready handshake, plus a segment-start flag that forces the accepted word to be word 0 of a new segment.

Top module: `seg_deinterleave`

## Requirements
- R1: While reset is held and in the first cycle after it, inReady is 1, outValid is 0 and frameErr is 0.
- R2: Within a segment, word positions 0..LANES-1 are analog values, LANES..2*LANES-1 are lower stamp halves and 2*LANES..3*LANES-1 are upper stamp halves. The record for lane i carries outSample = word i and outStamp = {word 2*LANES+i, word LANES+i}. Cycles with inValid low do not advance the position.
- R3: Records leave in lane order 0, 1, ..., LANES-1, each exactly once per segment.
- R4: The record of lane i is first offered (outValid 1) in the cycle after the upper-half word of lane i is accepted, and never earlier.
- R5: While outValid is 1 and outReady is 0, outValid stays 1 and outSample and outStamp stay unchanged.
- R6: After a full segment has been accepted, inReady is 0 until every record of that segment has been taken. The first word of the next segment is accepted only after that.
- R7: An accepted word with segStart 1 at a position other than 0 raises frameErr for exactly the following cycle. That word is taken as word 0 of a new segment.
- R8: segStart 1 on a word at position 0 raises no frameErr. segStart 1 while inValid is 0 has no effect on the position.
- R9: If segStart arrives while records of a restarted segment are still waiting, inReady stays 0 until those records are delivered, and the restarting word is accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| segStart | input | 1 | Marks the presented word as word 0 of a segment |
| inValid | input | 1 | Input word present |
| inWord | input | WORD_W | Input data word |
| inReady | output | 1 | Input word is accepted when inValid and inReady are 1 |
| outValid | output | 1 | Record present |
| outReady | input | 1 | Consumer takes the record when outValid and outReady are 1 |
| outSample | output | WORD_W | Analog value of the record |
| outStamp | output | 2*WORD_W | Rejoined timestamp, upper half in the top bits |
| frameErr | output | 1 | One-cycle pulse after an early segment restart |

## Verification
The embedded assertions check the following on every cycle:
- the read position never passes the count of arrived upper halves, and that count stays within one segment;
- the offered record holds under backpressure;
- outValid only rises after an accepted input word;
- frameErr only follows an accepted word that carried segStart.

Other behaviours depend on word values and on the order of events across a whole segment. These include the lane pairing of the three fields, the exact lane order, the drain-before-restart stall and the delivery of partial records on an early restart. Only the bench's segment scenarios can show them, by comparing every record against values computed from the segment and lane numbers.

// File: rtl/segdi_pkg.sv
package segdi_pkg;

  // Field that a word belongs to, chosen by its position in the segment.
  typedef enum logic [1:0] {
    GRP_SAMPLE = 2'd0,
    GRP_LOW    = 2'd1,
    GRP_HIGH   = 2'd2
  } grp_e;

  // Write strobes from control to the storage banks.
  typedef struct packed {
    logic wrHigh;
    logic wrLow;
    logic wrSample;
  } wrStrobes_t;

  localparam int NUM_FIELDS = 3;

endpackage

// File: rtl/segdi_ctrl.sv
module segdi_ctrl
  import segdi_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic segStart,
  input  logic inValid,
  input  logic outReady,
  output logic inReady,
  output logic outValid,
  output logic frameErr,
  output wrStrobes_t wrStb,
  output logic [$clog2(LANES)-1:0] wrLane,
  output logic [$clog2(LANES)-1:0] rdLane
);

  localparam int WORDS  = NUM_FIELDS * LANES;
  localparam int CNT_W  = $clog2(WORDS);
  localparam int LANE_W = $clog2(LANES);
  localparam int PTR_W  = $clog2(LANES + 1);

  logic [CNT_W-1:0] wordIdx;
  logic [CNT_W-1:0] effIdx;
  logic [PTR_W-1:0] hiCount;
  logic [PTR_W-1:0] rdPtr;
  grp_e             grp;
  logic [LANE_W-1:0] lane;
  logic             pending;
  logic             accept;
  logic             outFire;
  logic             lastWord;
  logic             segHead;

  // Position of the presented word, with segStart forcing position 0.
  always_comb begin
    effIdx = segStart ? '0 : wordIdx;
    if (effIdx < CNT_W'(LANES)) begin
      grp  = GRP_SAMPLE;
      lane = LANE_W'(effIdx);
    end else if (effIdx < CNT_W'(2 * LANES)) begin
      grp  = GRP_LOW;
      lane = LANE_W'(effIdx - CNT_W'(LANES));
    end else begin
      grp  = GRP_HIGH;
      lane = LANE_W'(effIdx - CNT_W'(2 * LANES));
    end
  end

  assign pending  = (rdPtr != hiCount);
  assign segHead  = (effIdx == '0);
  assign lastWord = (effIdx == CNT_W'(WORDS - 1));
  // A new segment may not begin while completed records are still waiting.
  assign inReady  = !(pending && (segStart || (wordIdx == '0)));
  assign accept   = inValid && inReady;
  assign outValid = pending;
  assign outFire  = outValid && outReady;

  assign wrStb.wrSample = accept && (grp == GRP_SAMPLE);
  assign wrStb.wrLow    = accept && (grp == GRP_LOW);
  assign wrStb.wrHigh   = accept && (grp == GRP_HIGH);
  assign wrLane         = lane;
  assign rdLane         = LANE_W'(rdPtr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordIdx  <= '0;
      hiCount  <= '0;
      rdPtr    <= '0;
      frameErr <= 1'b0;
    end else begin
      frameErr <= accept && segStart && (wordIdx != '0);
      if (accept) begin
        wordIdx <= lastWord ? '0 : effIdx + CNT_W'(1);
        if (segHead) begin
          hiCount <= '0;
        end else if (grp == GRP_HIGH) begin
          hiCount <= PTR_W'(lane) + PTR_W'(1);
        end
      end
      if (accept && segHead) begin
        rdPtr <= '0;
      end else if (outFire) begin
        rdPtr <= rdPtr + PTR_W'(1);
      end
    end
  end

  // R3: reading never overtakes the arrived upper halves
  p_rd_behind_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdPtr <= hiCount);

  // R2: upper-half count stays inside one segment
  p_hi_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hiCount <= PTR_W'(LANES));

  // R7: an error pulse is always caused by an accepted restart
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frameErr |-> $past(inValid && inReady && segStart));

endmodule

// File: rtl/segdi_data.sv
module segdi_data
  import segdi_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int WORD_W = 32
) (
  input  logic clk,
  input  logic [WORD_W-1:0] inWord,
  input  wrStrobes_t wrStb,
  input  logic [$clog2(LANES)-1:0] wrLane,
  input  logic [$clog2(LANES)-1:0] rdLane,
  output logic [WORD_W-1:0] outSample,
  output logic [2*WORD_W-1:0] outStamp
);

  logic [NUM_FIELDS-1:0] wrVec;
  logic [NUM_FIELDS-1:0][WORD_W-1:0] rdWord;

  assign wrVec = {wrStb.wrHigh, wrStb.wrLow, wrStb.wrSample};

  // One storage bank per field, all indexed by lane.
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gBank
    logic [WORD_W-1:0] mem [LANES];
    always_ff @(posedge clk) begin
      if (wrVec[g]) begin
        mem[wrLane] <= inWord;
      end
    end
    assign rdWord[g] = mem[rdLane];
  end

  assign outSample = rdWord[GRP_SAMPLE];
  assign outStamp  = {rdWord[GRP_HIGH], rdWord[GRP_LOW]};

endmodule

// File: rtl/seg_deinterleave.sv
module seg_deinterleave
  import segdi_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                segStart,
  input  logic                inValid,
  input  logic [WORD_W-1:0]   inWord,
  output logic                inReady,
  output logic                outValid,
  input  logic                outReady,
  output logic [WORD_W-1:0]   outSample,
  output logic [2*WORD_W-1:0] outStamp,
  output logic                frameErr
);

  localparam int LANE_W = $clog2(LANES);

  wrStrobes_t        wrStb;
  logic [LANE_W-1:0] wrLane;
  logic [LANE_W-1:0] rdLane;

  segdi_ctrl #(.LANES(LANES)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .segStart (segStart),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .frameErr (frameErr),
    .wrStb    (wrStb),
    .wrLane   (wrLane),
    .rdLane   (rdLane)
  );

  segdi_data #(.LANES(LANES), .WORD_W(WORD_W)) uData (
    .clk       (clk),
    .inWord    (inWord),
    .wrStb     (wrStb),
    .wrLane    (wrLane),
    .rdLane    (rdLane),
    .outSample (outSample),
    .outStamp  (outStamp)
  );

  // R5: an offered record is held until it is taken
  p_out_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outSample) && $stable(outStamp)));

  // R4: a record only appears after an input word was accepted
  p_rise_after_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |-> $past(inValid && inReady));

endmodule

// File: tb/seg_deinterleave_test.sv
`timescale 1ns/1ps
module seg_deinterleave_test;

  localparam int WORD_W = 32;
  localparam int LANES  = 32;
  localparam int WORDS  = 3 * LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic segStart = 1'b0;
  logic inValid = 1'b0;
  logic [WORD_W-1:0] inWord = '0;
  logic inReady;
  logic outValid;
  logic outReady = 1'b1;
  logic [WORD_W-1:0] outSample;
  logic [2*WORD_W-1:0] outStamp;
  logic frameErr;

  int tests = 0;
  int fails = 0;
  int errSeen = 0;
  int outMode = 0;
  logic [95:0] expQ[$];

  always #4 clk = ~clk;

  seg_deinterleave #(.WORD_W(WORD_W), .LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .segStart(segStart), .inValid(inValid),
    .inWord(inWord), .inReady(inReady), .outValid(outValid),
    .outReady(outReady), .outSample(outSample), .outStamp(outStamp),
    .frameErr(frameErr)
  );

  function automatic logic [31:0] sampleOf(int s, int i);
    return 32'hA000_0000 ^ 32'(s << 8) ^ 32'(i);
  endfunction
  function automatic logic [31:0] lowOf(int s, int i);
    return 32'h1000_0000 + 32'(s * 97) + 32'(i * 3);
  endfunction
  function automatic logic [31:0] highOf(int s, int i);
    return 32'h5000_0000 + 32'(s * 7) + 32'(i);
  endfunction
  function automatic logic [31:0] wordOf(int s, int pos);
    if (pos < LANES) return sampleOf(s, pos);
    else if (pos < 2 * LANES) return lowOf(s, pos - LANES);
    else return highOf(s, pos - 2 * LANES);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Output consumer pattern
  initial begin
    logic [7:0] lfsr = 8'h5B;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (outMode)
        0: outReady = 1'b1;
        1: outReady = lfsr[0] | lfsr[3];
        default: outReady = 1'b0;
      endcase
    end
  end

  // Record monitor: content, order, hold and early-valid checks
  initial begin
    logic holdPrev = 1'b0;
    logic [31:0] prevSample = '0;
    logic [63:0] prevStamp = '0;
    logic [95:0] e;
    forever begin
      @(negedge clk);
      #2;
      if (!rst_n) begin
        holdPrev = 1'b0;
        continue;
      end
      if (holdPrev) begin
        chk(outValid && outSample == prevSample && outStamp == prevStamp,
            "R5 record held under backpressure", {outValid, outSample}, {1'b1, prevSample});
      end
      if (outValid && expQ.size() == 0) begin
        chk(1'b0, "R4 record offered before its upper half", 64'(outSample), 64'h0);
      end
      if (outValid && outReady && expQ.size() != 0) begin
        e = expQ.pop_front();
        chk(outSample == e[95:64], "R3 lane order / R2 sample field", 64'(outSample), 64'(e[95:64]));
        chk(outStamp == e[63:0], "R2 rejoined stamp", outStamp, e[63:0]);
      end
      holdPrev   = outValid && !outReady;
      prevSample = outSample;
      prevStamp  = outStamp;
      if (frameErr) errSeen++;
    end
  end

  task automatic sendWord(int s, int pos, bit start, int gap);
    bit rdy;
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      segStart = 1'b0;
    end
    @(negedge clk);
    inValid = 1'b1;
    segStart = start;
    inWord = wordOf(s, pos);
    forever begin
      #1;
      rdy = inReady;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    if (pos >= 2 * LANES) begin
      expQ.push_back({sampleOf(s, pos - 2 * LANES), highOf(s, pos - 2 * LANES), lowOf(s, pos - 2 * LANES)});
    end
    #1;
    inValid = 1'b0;
    segStart = 1'b0;
  endtask

  task automatic sendRange(int s, int first, int last, int gap);
    for (int p = first; p <= last; p++) sendWord(s, p, p == 0, gap);
  endtask

  task automatic drain();
    outMode = 0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int errBase;
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk(inReady == 1'b1, "R1 inReady in reset", 64'(inReady), 64'd1);
    chk(outValid == 1'b0, "R1 outValid in reset", 64'(outValid), 64'd0);
    chk(frameErr == 1'b0, "R1 frameErr in reset", 64'(frameErr), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(inReady == 1'b1 && outValid == 1'b0 && frameErr == 1'b0, "R1 state after reset",
        {inReady, outValid, frameErr}, 64'h4);

    // R2 R3: sweep of segments under input gaps and output backpressure
    for (int s = 0; s < 6; s++) begin
      outMode = s % 2;
      sendRange(s, 0, WORDS - 1, s % 3);
      drain();
      chk(expQ.size() == 0, "R3 all records delivered", 64'(expQ.size()), 64'd0);
    end
    chk(errSeen == 0, "R8 no error on aligned segments", 64'(errSeen), 64'd0);

    // R4 R6: first record timing and drain stall
    outMode = 2;
    sendRange(10, 0, 2 * LANES - 1, 0);
    repeat (2) @(negedge clk);
    #2;
    chk(outValid == 1'b0, "R4 no record before upper half", 64'(outValid), 64'd0);
    sendWord(10, 2 * LANES, 1'b0, 0);
    #2;
    chk(outValid == 1'b1, "R4 record valid one cycle after upper half", 64'(outValid), 64'd1);
    chk(outSample == sampleOf(10, 0), "R4 first record content", 64'(outSample), 64'(sampleOf(10, 0)));
    sendRange(10, 2 * LANES + 1, WORDS - 1, 0);
    @(negedge clk);
    inValid = 1'b1;
    segStart = 1'b1;
    inWord = wordOf(11, 0);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(inReady == 1'b0, "R6 input stalled while records wait", 64'(inReady), 64'd0);
      @(negedge clk);
    end
    outMode = 0;
    errBase = errSeen;
    sendWord(11, 0, 1'b1, 0);
    chk(expQ.size() == 0, "R6 previous segment drained first", 64'(expQ.size()), 64'd0);
    sendRange(11, 1, WORDS - 1, 0);
    drain();
    chk(errSeen == errBase, "R8 aligned start raises no error", 64'(errSeen), 64'(errBase));

    // R7: early restart in the analog phase
    errBase = errSeen;
    sendRange(12, 0, 9, 0);
    sendWord(13, 0, 1'b1, 0);
    #2;
    chk(frameErr == 1'b1, "R7 frameErr after early restart", 64'(frameErr), 64'd1);
    @(posedge clk);
    #3;
    chk(frameErr == 1'b0, "R7 frameErr lasts one cycle", 64'(frameErr), 64'd0);
    sendRange(13, 1, WORDS - 1, 1);
    drain();
    chk(errSeen == errBase + 1, "R7 one error pulse", 64'(errSeen), 64'(errBase + 1));

    // R8: segStart without inValid is ignored
    errBase = errSeen;
    sendRange(14, 0, 39, 0);
    @(negedge clk);
    segStart = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    segStart = 1'b0;
    sendRange(14, 40, WORDS - 1, 0);
    drain();
    chk(errSeen == errBase, "R8 idle segStart ignored", 64'(errSeen), 64'(errBase));

    // R9: early restart during the upper-half phase
    outMode = 2;
    sendRange(15, 0, 2 * LANES + 4, 0);
    @(negedge clk);
    inValid = 1'b1;
    segStart = 1'b1;
    inWord = wordOf(16, 0);
    #1;
    chk(inReady == 1'b0, "R9 restart held while partial records wait", 64'(inReady), 64'd0);
    outMode = 0;
    sendWord(16, 0, 1'b1, 0);
    chk(expQ.size() == 0, "R9 partial records delivered first", 64'(expQ.size()), 64'd0);
    #2;
    chk(frameErr == 1'b1, "R9 R7 restart flagged", 64'(frameErr), 64'd1);
    sendRange(16, 1, WORDS - 1, 0);
    drain();

    chk(expQ.size() == 0, "R3 nothing left undelivered", 64'(expQ.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule